// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority Vote

This block turns an asynchronous serial line into bytes. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. An external divider supplies a one-clock `baud_tick` enable at 16 times the bit rate. Setting `half_rate` tells the receiver that the tick runs at only 8 times the bit rate. The receiver reads this input when a frame starts, and it stays fixed for that frame.

The line passes through a two-flop synchroniser. A falling edge on an idle line starts a fresh bit timer, so no timing is carried over from the frame before. The receiver takes three samples around the centre of each bit, and the bit value is the majority of those three. If the start bit votes high, it is treated as a glitch and the frame is dropped. At the stop-bit vote the byte is presented, and the receiver goes straight back to looking for a new edge. It does not wait out the rest of the stop bit, so it keeps working on back-to-back frames whose rate differs from nominal by a few percent.

The output is a one-cycle strobe with no back-pressure, because a serial line cannot be paused. The consumer must take `rx_data` in the cycle that `rx_valid` is high. After that, `rx_data` keeps its value until the next strobe.

Top module: `uart_rx_os`

## Requirements
- R1: After reset, `rx_valid` and `rx_frame_err` are 0, `rx_data` is 0x00, and the receiver treats the line as idle (high).
- R2: Only a high-to-low transition of the synchronised line starts a frame. The bit timer restarts from zero on every such edge, whatever the phase of `baud_tick`.
- R3: With `half_rate`=0, a bit is 16 ticks long. The bit is voted from ticks 7, 8 and 9, counted from 1 after the edge that starts it.
- R4: With `half_rate`=1, a bit is 8 ticks long and is voted from ticks 3, 4 and 5. The mode is captured at the start edge.
- R5: Each bit value is the majority of its three samples, so a disturbance seen by a single sample does not change the bit.
- R6: If the start bit votes high, the frame is abandoned, no strobe is produced, and the receiver returns to hunting.
- R7: Data bits are assembled least significant bit first into `rx_data`. `rx_data` changes only in a cycle where `rx_valid` is 1.
- R8: `rx_valid` is high for exactly one clock. That clock follows a `baud_tick` cycle: the one in which the stop bit was voted.
- R9: If the stop bit votes low, `rx_frame_err` is 1 in the strobe cycle, and the received byte is still presented. `rx_frame_err` is never 1 without `rx_valid`.
- R10: The receiver hunts for a new edge right after the stop vote. A frame that begins up to about 0.3 bit before the nominal end of the previous stop bit is received, and so are back-to-back frames sent 3.5% fast or slow, in both modes.
- R11: Idle gaps of any length between frames are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling enable, one clock wide |
| half_rate | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe for a received frame |
| rx_frame_err | output | 1 | Stop bit read low; qualified by rx_valid |

## Verification
A table of frames covers both tick ratios. In it, the bit period is set to nominal, 3.5% long and 3.5% short, and frames are sent back to back or after idle gaps of odd lengths. The alternating, all-zero, all-one and single-bit bytes expose bit-order and timing-drift faults; the 3.5% frames pass only if sampling sits near the bit centre and resynchronises on every start edge. Directed frames then separate the remaining behaviours. A short low pulse checks glitch rejection. A stop bit held low checks framing-error reporting. A stop bit cut short checks that hunting resumes early, and a sub-tick spike inside a data bit checks that the vote outweighs a single sample.

// File: rtl/uart_rx_os_pkg.sv
package uart_rx_os_pkg;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_os_sync.sv
// Synchroniser chain for the serial line plus falling-edge detect.
module uart_rx_os_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last <= 1'b1;
    else        last <= chain[STAGES-1];
  end

  assign line = chain[STAGES-1];
  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/uart_rx_os_timer.sv
// Counts oversampling ticks inside a bit and marks the three centre samples.
module uart_rx_os_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic run,
  input  logic half_rate,
  output logic samp_en,
  output logic vote_en
);
  localparam int CNT_W = $clog2(OSR + 1);
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(OSR);
  localparam logic [CNT_W-1:0] HALF_N = CNT_W'(OSR / 2);

  logic             half_q;
  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] tnum;
  logic [CNT_W-1:0] nticks;
  logic [CNT_W-1:0] mid;
  logic             in_win;
  logic             bit_end;

  always_comb begin
    nticks  = half_q ? HALF_N : FULL_N;
    mid     = nticks >> 1;
    tnum    = ph + CNT_W'(1);
    in_win  = (tnum == mid - CNT_W'(1)) || (tnum == mid) || (tnum == mid + CNT_W'(1));
    bit_end = (tnum == nticks);
  end

  // mode is frozen per frame on the start edge
  always_ff @(posedge clk) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (restart) half_q <= half_rate;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             ph <= '0;
    else if (restart)       ph <= '0;
    else if (run && tick)   ph <= bit_end ? '0 : tnum;
  end

  assign samp_en = run & tick & in_win;
  assign vote_en = run & tick & (tnum == mid + CNT_W'(1));
endmodule

// File: rtl/uart_rx_os_voter.sv
// Holds the first two centre samples; the third is the live line value.
module uart_rx_os_voter
  import uart_rx_os_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic line,
  output logic vote
);
  logic [1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= 2'b11;
    else if (samp_en) held <= {held[0], line};
  end

  assign vote = maj3(held[1], held[0], line);
endmodule

// File: rtl/uart_rx_os_ctrl.sv
// Frame sequencer: start check, data shift, stop check and output strobe.
module uart_rx_os_ctrl
  import uart_rx_os_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall,
  input  logic                 vote_en,
  input  logic                 vote,
  output logic                 restart,
  output logic                 run,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  rx_state_e            st;
  logic [BIT_W-1:0]     bcnt;
  logic [DATA_BITS-1:0] shreg;

  assign restart = (st == RX_HUNT) && fall;
  assign run     = (st != RX_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= RX_HUNT;
      bcnt         <= '0;
      shreg        <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      unique case (st)
        RX_HUNT: if (fall) st <= RX_START;
        RX_START: if (vote_en) begin
          bcnt <= '0;
          st   <= vote ? RX_HUNT : RX_DATA;   // high vote: glitch
        end
        RX_DATA: if (vote_en) begin
          shreg <= {vote, shreg[DATA_BITS-1:1]};
          if (bcnt == LAST_BIT) st <= RX_STOP;
          else                  bcnt <= bcnt + BIT_W'(1);
        end
        RX_STOP: if (vote_en) begin
          rx_data      <= shreg;
          rx_valid     <= 1'b1;
          rx_frame_err <= ~vote;
          st           <= RX_HUNT;            // hunt again at stop centre
        end
        default: st <= RX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 half_rate,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);
  logic line, fall, restart, run, samp_en, vote_en, vote;

  uart_rx_os_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .line(line), .fall(fall)
  );

  uart_rx_os_timer #(.OSR(OSR)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .restart(restart), .run(run),
    .half_rate(half_rate), .samp_en(samp_en), .vote_en(vote_en)
  );

  uart_rx_os_voter u_voter (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line(line), .vote(vote)
  );

  uart_rx_os_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall(fall), .vote_en(vote_en), .vote(vote),
    .restart(restart), .run(run), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err)
  );
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 baud_tick,
  input logic                 run,
  input logic                 samp_en,
  input logic                 vote_en,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 rx_frame_err
);
  p_valid_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(baud_tick));

  p_err_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> rx_valid);

  p_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  p_vote_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vote_en |-> samp_en);

  p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |-> (baud_tick && run));
endmodule

bind uart_rx_os uart_rx_os_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .run(run),
  .samp_en(samp_en), .vote_en(vote_en), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
);

// File: tb/uart_rx_os_test.sv
`timescale 1ns/1ps
module uart_rx_os_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       half_rate = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_frame_err;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_rx_os uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .half_rate(half_rate),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  // tick source: every 4 clocks at 16x, every 8 at 8x -> 640 ns per bit
  int tdiv = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv <= 0; baud_tick <= 1'b0;
    end else begin
      tdiv      <= (tdiv >= (half_rate ? 7 : 3)) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == 0);
    end
  end

  // capture every strobe
  logic [7:0] cap_data [0:63];
  logic       cap_err  [0:63];
  int         cap_n = 0;
  always @(negedge clk) begin
    if (rst_n && rx_valid && cap_n < 64) begin
      cap_data[cap_n] = rx_data;
      cap_err[cap_n]  = rx_frame_err;
      cap_n++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input real bit_ns, input logic stop_v,
                            input real stop_frac, input int spike_bit);
    rxd = 1'b0; #(bit_ns);
    for (int i = 0; i < 8; i++) begin
      if (i == spike_bit) begin
        rxd = d[i];  #(bit_ns / 2.0 - 15.0);
        rxd = ~d[i]; #(30.0);
        rxd = d[i];  #(bit_ns / 2.0 - 15.0);
      end else begin
        rxd = d[i]; #(bit_ns);
      end
    end
    rxd = stop_v; #(bit_ns * stop_frac);
    rxd = 1'b1;
  endtask

  // table: data, mode, rate offset in permille, idle gap before frame (ns)
  localparam int NV = 12;
  localparam logic [7:0] V_DATA [NV] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C,
                                         8'h96, 8'h5A, 8'h01, 8'hFE, 8'h7F, 8'hC5};
  localparam logic       V_MODE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int         V_OFF  [NV] = '{0, 35, -35, 35, -35, 0, 0, 35, -35, 35, -35, 0};
  localparam int         V_GAP  [NV] = '{2013, 0, 0, 0, 5003, 0, 3007, 0, 0, 0, 1999, 0};

  initial begin
    #1_500_000;
    n_bad++; n_vec++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (10) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
    check(rx_frame_err == 1'b0, "R1 err", int'(rx_frame_err), 0);
    check(rx_data == 8'h00, "R1 data", int'(rx_data), 0);

    // table walk: R3 (16x), R4 (8x), R7 bit order, R10 drift, R11/R2 gaps
    for (int v = 0; v < NV; v++) begin
      half_rate = V_MODE[v];
      #(V_GAP[v]);
      send_frame(V_DATA[v], 640.0 * real'(1000 + V_OFF[v]) / 1000.0, 1'b1, 1.0, -1);
    end
    #1000;
    check(cap_n == NV, "R10 frame count", cap_n, NV);
    for (int v = 0; v < NV; v++) begin
      check(cap_data[v] == V_DATA[v], V_MODE[v] ? "R4 R7 data" : "R3 R7 data",
            int'(cap_data[v]), int'(V_DATA[v]));
      check(cap_err[v] == 1'b0, "R10 no framing error", int'(cap_err[v]), 0);
    end

    // R6: glitch shorter than half a bit gives no byte, next frame still fine
    half_rate = 1'b0;
    #1000;
    base = cap_n;
    rxd = 1'b0; #120; rxd = 1'b1;
    #8000;
    check(cap_n == base, "R6 glitch ignored", cap_n, base);
    send_frame(8'h4B, 640.0, 1'b1, 1.0, -1);
    #500;
    check(cap_n == base + 1 && cap_data[base] == 8'h4B, "R6 frame after glitch",
          int'(cap_data[base]), 8'h4B);

    // R9: stop bit low -> framing error with byte
    #1000;
    base = cap_n;
    send_frame(8'hE7, 640.0, 1'b0, 1.0, -1);
    rxd = 1'b0; #640; rxd = 1'b1;
    #2000;
    check(cap_n == base + 1, "R9 strobe count", cap_n, base + 1);
    check(cap_err[base] == 1'b1, "R9 framing error", int'(cap_err[base]), 1);
    check(cap_data[base] == 8'hE7, "R9 data kept", int'(cap_data[base]), 8'hE7);

    // R10: stop bit cut to 0.7 bit, next frame follows at once
    base = cap_n;
    send_frame(8'h12, 640.0, 1'b1, 0.7, -1);
    send_frame(8'h34, 640.0, 1'b1, 1.0, -1);
    #500;
    check(cap_n == base + 2, "R10 early frame count", cap_n, base + 2);
    check(cap_data[base] == 8'h12 && cap_err[base] == 1'b0, "R10 first byte",
          int'(cap_data[base]), 8'h12);
    check(cap_data[base+1] == 8'h34 && cap_err[base+1] == 1'b0, "R10 early byte",
          int'(cap_data[base+1]), 8'h34);

    // R5: 30 ns spike at a bit centre is outvoted, both modes
    #1000;
    base = cap_n;
    send_frame(8'h00, 640.0, 1'b1, 1.0, 3);
    #500;
    check(cap_data[base] == 8'h00, "R5 spike 16x", int'(cap_data[base]), 8'h00);
    half_rate = 1'b1;
    #1000;
    send_frame(8'hFF, 640.0, 1'b1, 1.0, 5);
    #500;
    check(cap_data[base+1] == 8'hFF, "R5 spike 8x", int'(cap_data[base+1]), 8'hFF);
    check(rx_valid == 1'b0, "R8 strobe gone", int'(rx_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule